// File: doc/BRIEF.md
# SPI Master Status Flag Register

This block keeps the read-only status word of an SPI master controller that sits on a memory-mapped register bus. It follows the state of the transmit buffer and the receive buffer, and it latches a mode-fault condition. It observes the bus strobes, the transmit-data write strobe, the receive-data read strobe, the transfer-complete pulse from the shift engine and the slave-select input. From these it builds a 32-bit status word that is always presented at its output, and it raises a one-cycle interrupt when a mode fault is first detected.

A parameter chooses the buffer model. With FIFOs, the block keeps transmit and receive occupancy counts and derives the full and empty flags from them. Without FIFOs, the flags model single data registers. The status word is at offset 0x64. Writes to it have no effect, and a read of it clears the mode-fault flag. A second parameter builds the controller as master-only, in which case the fault logic is tied off. Every flag changes in the clock cycle after the strobe that causes it.

Top module: `spi_status_word`

## Requirements
- R1: After synchronous reset, the status word reads 0x00000005: Rx_Empty=1, Tx_Empty=1, and all other bits 0.
- R2: Bit layout, with bit 0 as the LSB: bit 0 Rx_Empty, bit 1 Rx_Full, bit 2 Tx_Empty, bit 3 Tx_Full, bit 4 mode fault. Bits 31:5 always read 0.
- R3: A bus write to address 0x64, or to any other address, with no other strobe active, leaves the status word unchanged.
- R4: The fault bit sets in the cycle after a clock edge at which the active-low select input is sampled low after being sampled high on the previous edge while the master input is 1. Such an edge has no effect while the master input is 0.
- R5: A status read clears the fault bit. A status read is bus_rd=1, bus_wr=0 and address 0x64. A new fault detected in the same cycle wins and keeps the bit set. Reads at other addresses do not clear it.
- R6: fault_irq is high for exactly one cycle, and that cycle is the first cycle in which the fault bit reads 1 after reading 0.
- R7: With MASTER_ONLY=1, the fault bit and fault_irq are always 0.
- R8: With FIFOs, a transmit write adds one to the transmit occupancy. A write at full is dropped unless a completion arrives in the same cycle. A completion subtracts one when the occupancy is nonzero. Tx_Full means occupancy equals FIFO_DEPTH, and Tx_Empty means occupancy is 0.
- R9: With FIFOs, a completion adds one to the receive occupancy. A completion at full is dropped unless a receive read arrives in the same cycle. A receive read subtracts one when the occupancy is nonzero. Rx_Full means occupancy equals FIFO_DEPTH, and Rx_Empty means occupancy is 0.
- R10: Without FIFOs, a transmit write sets Tx_Full and clears Tx_Empty. A completion without a write clears Tx_Full and sets Tx_Empty. When both arrive together, the write wins.
- R11: Without FIFOs, a completion sets Rx_Full and a receive read alone clears it. When both arrive together, the completion wins. Rx_Empty is always the complement of Rx_Full.
- R12: With FIFOs, a transmit write and a completion in the same cycle leave a nonzero transmit occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register-bus read strobe |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_addr | input | ADDR_W | Register-bus byte offset |
| tx_wr_stb | input | 1 | Transmit data write strobe |
| rx_rd_stb | input | 1 | Receive data read strobe |
| xfer_done | input | 1 | One-cycle transfer-complete pulse |
| ss_in_n | input | 1 | Slave-select input, active low |
| cfg_master | input | 1 | Controller configured as master |
| stat_word | output | 32 | Status word |
| fault_irq | output | 1 | One-cycle mode-fault interrupt |

## Verification
A wrong occupancy count does not stay hidden. It shows up as a full or empty flag that asserts early or late at the status port, and in the FIFO build it is visible at the latest when the count reaches zero or FIFO_DEPTH. Every flag is a registered function of the strobes, so each mistake appears one cycle after the strobe that caused it. A fault latch that clears or sets wrongly shows on bit 4 in the next cycle, and the same mistake appears on fault_irq as a missing or doubled pulse. The FIFO, single-register and master-only builds are driven side by side and compared every cycle against an arithmetic model.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int STAT_W = 32;
    localparam int FLAG_W = 5;

    // Flag bundle, MSB first: fault is bit 4 and rx_empty is bit 0.
    typedef struct packed {
        logic modf;
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } stat_flags_t;

    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2
    } occ_op_t;

    function automatic occ_op_t pick_op(input logic inc, input logic dec);
        if (inc && !dec) return OCC_INC;
        if (dec && !inc) return OCC_DEC;
        return OCC_HOLD;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input stat_flags_t f);
        return {{(STAT_W-FLAG_W){1'b0}}, f};
    endfunction

endpackage

// File: rtl/spi_tx_tracker.sv
module spi_tx_tracker
    import spi_stat_pkg::*;
#(
    parameter bit FIFO_EN    = 1'b1,
    parameter int FIFO_DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic done,
    output logic full,
    output logic empty
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] FULL_V = CW'(FIFO_DEPTH);

    generate
        if (FIFO_EN) begin : g_fifo
            logic [CW-1:0] cnt;
            logic inc, dec;
            occ_op_t op;

            // A completion frees a slot, so a write at full is accepted alongside it.
            assign inc = wr_stb && ((cnt != FULL_V) || done);
            assign dec = done && (cnt != '0);
            assign op  = pick_op(inc, dec);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else begin
                    case (op)
                        OCC_INC: cnt <= cnt + 1'b1;
                        OCC_DEC: cnt <= cnt - 1'b1;
                        default: cnt <= cnt;
                    endcase
                end
            end

            assign full  = (cnt == FULL_V);
            assign empty = (cnt == '0);
        end else begin : g_reg
            logic full_q, empty_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    full_q  <= 1'b0;
                    empty_q <= 1'b1;
                end else if (wr_stb) begin
                    full_q  <= 1'b1;
                    empty_q <= 1'b0;
                end else if (done) begin
                    full_q  <= 1'b0;
                    empty_q <= 1'b1;
                end
            end

            assign full  = full_q;
            assign empty = empty_q;
        end
    endgenerate

endmodule

// File: rtl/spi_rx_tracker.sv
module spi_rx_tracker
    import spi_stat_pkg::*;
#(
    parameter bit FIFO_EN    = 1'b1,
    parameter int FIFO_DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic rd_stb,
    output logic full,
    output logic empty
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] FULL_V = CW'(FIFO_DEPTH);

    generate
        if (FIFO_EN) begin : g_fifo
            logic [CW-1:0] cnt;
            logic inc, dec;
            occ_op_t op;

            assign inc = done && ((cnt != FULL_V) || rd_stb);
            assign dec = rd_stb && (cnt != '0);
            assign op  = pick_op(inc, dec);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else begin
                    case (op)
                        OCC_INC: cnt <= cnt + 1'b1;
                        OCC_DEC: cnt <= cnt - 1'b1;
                        default: cnt <= cnt;
                    endcase
                end
            end

            assign full  = (cnt == FULL_V);
            assign empty = (cnt == '0);
        end else begin : g_reg
            logic full_q;

            // New data beats a drain landing in the same cycle.
            always_ff @(posedge clk) begin
                if (rst)         full_q <= 1'b0;
                else if (done)   full_q <= 1'b1;
                else if (rd_stb) full_q <= 1'b0;
            end

            assign full  = full_q;
            assign empty = ~full_q;
        end
    endgenerate

endmodule

// File: rtl/spi_fault_tracker.sv
module spi_fault_tracker #(
    parameter bit MASTER_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic ss_n,
    input  logic is_master,
    input  logic stat_rd,
    output logic modf,
    output logic irq
);
    generate
        if (MASTER_ONLY) begin : g_tied
            assign modf = 1'b0;
            assign irq  = 1'b0;
        end else begin : g_live
            logic ss_prev, modf_q, irq_q, set_ev;

            assign set_ev = ss_prev && !ss_n && is_master;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ss_prev <= 1'b1;
                    modf_q  <= 1'b0;
                    irq_q   <= 1'b0;
                end else begin
                    ss_prev <= ss_n;
                    irq_q   <= set_ev && !modf_q;
                    if (set_ev)       modf_q <= 1'b1;
                    else if (stat_rd) modf_q <= 1'b0;
                end
            end

            assign modf = modf_q;
            assign irq  = irq_q;
        end
    endgenerate

endmodule

// File: rtl/spi_status_word.sv
module spi_status_word
    import spi_stat_pkg::*;
#(
    parameter bit          FIFO_EN     = 1'b1,
    parameter int          FIFO_DEPTH  = 16,
    parameter bit          MASTER_ONLY = 1'b0,
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] STAT_OFFSET = 32'h64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              tx_wr_stb,
    input  logic              rx_rd_stb,
    input  logic              xfer_done,
    input  logic              ss_in_n,
    input  logic              cfg_master,
    output logic [STAT_W-1:0] stat_word,
    output logic              fault_irq
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = STAT_OFFSET[ADDR_W-1:0];

    logic        stat_rd;
    stat_flags_t flags;

    // A cycle carrying the write strobe is never a status read.
    assign stat_rd = bus_rd && !bus_wr && (bus_addr == STAT_ADDR);

    spi_tx_tracker #(.FIFO_EN(FIFO_EN), .FIFO_DEPTH(FIFO_DEPTH)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (tx_wr_stb),
        .done   (xfer_done),
        .full   (flags.tx_full),
        .empty  (flags.tx_empty)
    );

    spi_rx_tracker #(.FIFO_EN(FIFO_EN), .FIFO_DEPTH(FIFO_DEPTH)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .done   (xfer_done),
        .rd_stb (rx_rd_stb),
        .full   (flags.rx_full),
        .empty  (flags.rx_empty)
    );

    spi_fault_tracker #(.MASTER_ONLY(MASTER_ONLY)) u_fault (
        .clk       (clk),
        .rst       (rst),
        .ss_n      (ss_in_n),
        .is_master (cfg_master),
        .stat_rd   (stat_rd),
        .modf      (flags.modf),
        .irq       (fault_irq)
    );

    assign stat_word = pack_status(flags);

endmodule

// File: rtl/spi_status_word_chk.sv
module spi_status_word_chk #(
    parameter bit          FIFO_EN     = 1'b1,
    parameter bit          MASTER_ONLY = 1'b0,
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] STAT_OFFSET = 32'h64
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tx_wr_stb,
    input logic              xfer_done,
    input logic              ss_in_n,
    input logic [31:0]       stat_word,
    input logic              fault_irq
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        stat_word[31:5] == '0);

    p_tx_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(stat_word[3] && stat_word[2]));

    p_irq_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        fault_irq |-> (stat_word[4] && !$past(stat_word[4])));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        fault_irq |=> !fault_irq);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == STAT_OFFSET[ADDR_W-1:0] && ss_in_n)
        |=> !stat_word[4]);

    generate
        if (FIFO_EN) begin : g_fifo_chk
            p_write_unempties_r8: assert property (@(posedge clk) disable iff (rst)
                tx_wr_stb |=> !stat_word[2]);
        end else begin : g_reg_chk
            p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
                tx_wr_stb |=> (stat_word[3] && !stat_word[2]));
            p_done_empties_r10: assert property (@(posedge clk) disable iff (rst)
                (xfer_done && !tx_wr_stb) |=> (stat_word[2] && !stat_word[3]));
            p_rx_complement_r11: assert property (@(posedge clk) disable iff (rst)
                stat_word[0] == !stat_word[1]);
        end
        if (MASTER_ONLY) begin : g_mo_chk
            p_fault_tied_r7: assert property (@(posedge clk) disable iff (rst)
                !stat_word[4] && !fault_irq);
        end
    endgenerate

endmodule

bind spi_status_word spi_status_word_chk #(
    .FIFO_EN     (FIFO_EN),
    .MASTER_ONLY (MASTER_ONLY),
    .ADDR_W      (ADDR_W),
    .STAT_OFFSET (STAT_OFFSET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .tx_wr_stb (tx_wr_stb),
    .xfer_done (xfer_done),
    .ss_in_n   (ss_in_n),
    .stat_word (stat_word),
    .fault_irq (fault_irq)
);

// File: tb/spi_status_word_tb.sv
`timescale 1ns/1ps
module spi_status_word_tb;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        tx_wr_stb = 1'b0, rx_rd_stb = 1'b0, xfer_done = 1'b0;
    logic        ss_in_n = 1'b1, cfg_master = 1'b1;
    logic [31:0] w_f, w_n, w_m;
    logic        irq_f, irq_n, irq_m;

    int n_chk = 0, n_fail = 0;

    // model state
    int tc = 0, rc = 0;
    bit tf = 0, rf = 0, mf = 0, ssp = 1, irq_e = 0;

    always #2.5 clk = ~clk;

    spi_status_word #(.FIFO_EN(1'b1), .FIFO_DEPTH(D), .MASTER_ONLY(1'b0)) u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .tx_wr_stb(tx_wr_stb), .rx_rd_stb(rx_rd_stb), .xfer_done(xfer_done),
        .ss_in_n(ss_in_n), .cfg_master(cfg_master), .stat_word(w_f), .fault_irq(irq_f));

    spi_status_word #(.FIFO_EN(1'b0), .FIFO_DEPTH(D), .MASTER_ONLY(1'b0)) u_dut_nf (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .tx_wr_stb(tx_wr_stb), .rx_rd_stb(rx_rd_stb), .xfer_done(xfer_done),
        .ss_in_n(ss_in_n), .cfg_master(cfg_master), .stat_word(w_n), .fault_irq(irq_n));

    spi_status_word #(.FIFO_EN(1'b1), .FIFO_DEPTH(D), .MASTER_ONLY(1'b1)) u_dut_mo (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .tx_wr_stb(tx_wr_stb), .rx_rd_stb(rx_rd_stb), .xfer_done(xfer_done),
        .ss_in_n(ss_in_n), .cfg_master(cfg_master), .stat_word(w_m), .fault_irq(irq_m));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_fifo();
        return {27'b0, mf, (tc == D), (tc == 0), (rc == D), (rc == 0)};
    endfunction

    function automatic logic [31:0] exp_reg();
        return {27'b0, mf, tf, !tf, rf, !rf};
    endfunction

    task automatic step(input bit wr, input bit done, input bit rd, input bit ssn,
                        input bit master, input bit brd, input bit bwr, input logic [7:0] addr);
        bit srd, set_ev, inc, dec;
        logic [31:0] before_f, before_n;
        @(negedge clk);
        before_f = w_f; before_n = w_n;
        tx_wr_stb = wr; xfer_done = done; rx_rd_stb = rd; ss_in_n = ssn;
        cfg_master = master; bus_rd = brd; bus_wr = bwr; bus_addr = addr;
        @(posedge clk);
        srd = brd && !bwr && (addr == 8'h64);
        inc = wr && (tc < D || done); dec = done && (tc > 0);
        tc = tc + int'(inc) - int'(dec);
        inc = done && (rc < D || rd); dec = rd && (rc > 0);
        rc = rc + int'(inc) - int'(dec);
        if (wr) tf = 1; else if (done) tf = 0;
        if (done) rf = 1; else if (rd) rf = 0;
        set_ev = ssp && !ssn && master;
        irq_e = set_ev && !mf;
        if (set_ev) mf = 1; else if (srd) mf = 0;
        ssp = ssn;
        #1;
        if (wr && done) chk("R12 fifo tx write+done", {30'b0, w_f[3:2]}, {30'b0, exp_fifo()[3:2]});
        else            chk("R8 fifo tx flags", {30'b0, w_f[3:2]}, {30'b0, exp_fifo()[3:2]});
        chk("R9 fifo rx flags", {30'b0, w_f[1:0]}, {30'b0, exp_fifo()[1:0]});
        chk("R10 reg tx flags", {30'b0, w_n[3:2]}, {30'b0, exp_reg()[3:2]});
        chk("R11 reg rx flags", {30'b0, w_n[1:0]}, {30'b0, exp_reg()[1:0]});
        if (srd) chk("R5 fault after status read", {31'b0, w_f[4]}, {31'b0, mf});
        else     chk("R4 fault bit", {31'b0, w_f[4]}, {31'b0, mf});
        chk("R2 reserved bits", {5'b0, w_f[31:5]}, 32'b0);
        chk("R6 irq fifo build", {31'b0, irq_f}, {31'b0, irq_e});
        chk("R6 irq reg build", {31'b0, irq_n}, {31'b0, irq_e});
        chk("R7 master-only word", w_m, exp_fifo() & 32'hFFFF_FFEF);
        chk("R7 master-only irq", {31'b0, irq_m}, 32'b0);
        if (bwr && !wr && !done && !rd && ssn) begin
            chk("R3 write leaves fifo word", w_f, before_f);
            chk("R3 write leaves reg word", w_n, before_n);
        end
    endtask

    initial begin
        #1000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset word
        chk("R1 reset fifo", w_f, 32'h5);
        chk("R1 reset reg", w_n, 32'h5);
        chk("R1 reset master-only", w_m, 32'h5);

        // R3: writes to the status word and elsewhere, nothing else active
        step(0, 0, 0, 1, 1, 0, 1, 8'h64);
        step(0, 0, 0, 1, 1, 0, 1, 8'h10);
        step(1, 0, 0, 1, 1, 0, 0, 8'h00);
        step(0, 0, 0, 1, 1, 1, 1, 8'h64);

        // R4/R5/R6 directed: select edge with master low, then high, then reads
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 0, 0, 8'h00);
        step(0, 0, 0, 0, 1, 0, 0, 8'h00);
        step(0, 0, 0, 0, 1, 1, 0, 8'h60);
        step(0, 0, 0, 0, 1, 1, 0, 8'h64);
        step(0, 0, 0, 1, 1, 0, 0, 8'h00);
        step(0, 0, 0, 0, 1, 1, 0, 8'h64);

        // R8/R9/R10/R11/R12 sweep with biased phases: fill, drain, mixed
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                int pw, pd, pr;
                pw = (ph == 0) ? 70 : (ph == 1) ? 10 : 40;
                pd = (ph == 1) ? 60 : (ph == 2) ? 50 : 30;
                pr = (ph == 0) ? 10 : (ph == 1) ? 70 : 40;
                step($urandom_range(99) < pw, $urandom_range(99) < pd,
                     $urandom_range(99) < pr, $urandom_range(99) < 75,
                     $urandom_range(99) < 70, $urandom_range(99) < 20,
                     $urandom_range(99) < 10,
                     ($urandom_range(1) == 0) ? 8'h64 : 8'h60);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule